// File: doc/BRIEF.md
# Magnetic Latch Output Sequencer with Fault Retry

This block is the digital core of a three-wire magnetic latch sensor. It receives signed field samples over a valid/ready stream, compares them against a programmable operate threshold and a release threshold of opposite sign, and keeps a latched on/off state with hysteresis. The result is driven as a 2-bit output level code that means LOW, HIGH or FAULT. An output-polarity select swaps the meaning of LOW and HIGH.

Around the latch sits a small supervisor. It holds the output at FAULT through a power-on interval and until the first sample arrives. It runs a background diagnostic cycle at a fixed period, and that cycle includes a signal-path self-test with injected stimuli. It watches a set of internal fault flags and an overtemperature detector with hysteresis. On any fault it forces FAULT at once. While faulted, it re-runs the diagnostics once per retry period. It leaves FAULT only when a retry comes back clean, and then resumes from the latch state it held before the fault.

The sample stream never applies back-pressure. `smp_ready` goes high on the first clock after reset is released and stays high, so every cycle with `smp_valid` high counts as a transfer. A transfer made while the output is FAULT is consumed and discarded.

Top module: `hall_latch_diag`

## Requirements
- R1: After reset, `out_code` is FAULT (2'b11) for POR_TICKS cycles. It stays FAULT after that until the first valid sample has been accepted.
- R2: A sample strictly greater than `thr_op` sets the latch to on. A sample strictly less than `thr_rel` sets it to off. A sample equal to either threshold, or between them, leaves the latch unchanged. The output reflects the update in the cycle after the transfer.
- R3: If the first sample after power-on lies inside the hysteresis band, the latch starts in the off state.
- R4: Output encoding is LOW=2'b00, HIGH=2'b01, FAULT=2'b11, and 2'b10 never appears. With `invert`=0, on maps to LOW and off maps to HIGH. With `invert`=1 the mapping is swapped. FAULT is never affected by `invert`.
- R5: Any bit of `fault_flags` that is high at a clock edge outside power-on puts the block into the fault state at that edge. `fault_active` is then 1 and `out_code` is FAULT in the following cycle.
- R6: The retry timer restarts at each entry to the fault state. A retry runs every RETRY_TICKS cycles. A fault that has cleared gives exactly RETRY_TICKS cycles with `fault_active` high. A fault that persists keeps the output at FAULT indefinitely.
- R7: The block leaves the fault state only together with a one-cycle `diag_pass` pulse. The output stays FAULT until the next valid sample. That sample is evaluated against the latch state held from before the fault.
- R8: The overtemperature fault sets when `temp_c` is at or above 205. It clears only when `temp_c` is at or below 180.
- R9: At the end of every diagnostic period, the block checks that an injected stimulus of +TEST_AMP would operate the latch and that -TEST_AMP would release it. A missing transition is a fault.
- R10: Samples accepted while in the fault state do not change the latch.
- R11: During normal operation with no fault, `diag_pass` pulses once per DIAG_TICKS cycles.
- R12: `smp_ready` is 0 during reset and 1 from the first clock after reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Field sample valid |
| smp_ready | output | 1 | Sample stream ready, never deasserted after reset |
| smp_field | input | W | Signed field sample |
| thr_op | input | W | Signed operate threshold |
| thr_rel | input | W | Signed release threshold |
| invert | input | 1 | Output polarity swap |
| fault_flags | input | NF | Internal fault indications, any high is a fault |
| temp_c | input | TW | Signed junction temperature in degrees |
| out_code | output | 2 | Output level code |
| diag_pass | output | 1 | One-cycle pulse on a clean diagnostic or retry |
| fault_active | output | 1 | High while in the fault state |

## Verification
On every cycle, the assertions check these rules: the illegal code never appears; FAULT is shown throughout power-on and throughout a fault episode; a fault flag always moves the block into the fault state; the fault state is left only alongside `diag_pass`; and the latch is frozen while faulted. Only the bench scenarios can show the rest. These are the exact hysteresis edges at the thresholds, the start in the off state from inside the band, the exact retry length, the rate of `diag_pass`, the temperature hysteresis, the signal-path self-test, and the resumption from the held state, all under mixed random and directed samples.

// File: rtl/hl_pkg.sv
package hl_pkg;
  typedef enum logic [1:0] {
    ST_POR = 2'd0,
    ST_ARM = 2'd1,
    ST_RUN = 2'd2,
    ST_FLT = 2'd3
  } hl_state_e;

  localparam logic [1:0] CODE_LOW   = 2'b00;
  localparam logic [1:0] CODE_HIGH  = 2'b01;
  localparam logic [1:0] CODE_FAULT = 2'b11;

  function automatic logic [1:0] level_code(input logic on, input logic inv);
    return (on ^ inv) ? CODE_LOW : CODE_HIGH;
  endfunction
endpackage

// File: rtl/hl_tick_timer.sv
module hl_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done = en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr || done)  cnt_q <= '0;
    else if (en)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hl_schmitt.sv
module hl_schmitt #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] field,
  input  logic signed [W-1:0] op,
  input  logic signed [W-1:0] rel,
  input  logic                cur,
  output logic                nxt
);
  always_comb begin
    if (field > op)       nxt = 1'b1;
    else if (field < rel) nxt = 1'b0;
    else                  nxt = cur;
  end
endmodule

// File: rtl/hl_sigpath.sv
module hl_sigpath #(
  parameter int W        = 16,
  parameter int TEST_AMP = 1000
) (
  input  logic signed [W-1:0] op,
  input  logic signed [W-1:0] rel,
  output logic                fail
);
  localparam logic signed [W-1:0] AMP_P = W'(TEST_AMP);
  localparam logic signed [W-1:0] AMP_N = W'(-TEST_AMP);

  logic [1:0] miss;

  // leg 0 injects +AMP from off and expects on; leg 1 injects -AMP from on and expects off
  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic resp;
    hl_schmitt #(.W(W)) u_cmp (
      .field (g == 0 ? AMP_P : AMP_N),
      .op    (op),
      .rel   (rel),
      .cur   (g == 1),
      .nxt   (resp)
    );
    assign miss[g] = (resp != (g == 0));
  end

  assign fail = |miss;
endmodule

// File: rtl/hl_overtemp.sv
module hl_overtemp #(
  parameter int TW      = 10,
  parameter int OT_TRIP = 205,
  parameter int OT_HYS  = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [TW-1:0] temp_c,
  output logic                 hot
);
  localparam logic signed [TW-1:0] TRIP_V  = TW'(OT_TRIP);
  localparam logic signed [TW-1:0] CLEAR_V = TW'(OT_TRIP - OT_HYS);

  always_ff @(posedge clk) begin
    if (!rst_n)                hot <= 1'b0;
    else if (temp_c >= TRIP_V) hot <= 1'b1;
    else if (temp_c <= CLEAR_V) hot <= 1'b0;
  end
endmodule

// File: rtl/hall_latch_diag.sv
module hall_latch_diag
  import hl_pkg::*;
#(
  parameter int W           = 16,
  parameter int NF          = 4,
  parameter int TW          = 10,
  parameter int POR_TICKS   = 37500,
  parameter int DIAG_TICKS  = 6250,
  parameter int RETRY_TICKS = 500000,
  parameter int TEST_AMP    = 1000,
  parameter int OT_TRIP     = 205,
  parameter int OT_HYS      = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic signed [W-1:0]  smp_field,
  input  logic signed [W-1:0]  thr_op,
  input  logic signed [W-1:0]  thr_rel,
  input  logic                 invert,
  input  logic [NF-1:0]        fault_flags,
  input  logic signed [TW-1:0] temp_c,
  output logic [1:0]           out_code,
  output logic                 diag_pass,
  output logic                 fault_active
);
  hl_state_e st_q, st_d;
  logic latch_q, latch_d, latch_nxt;
  logic pass_d;
  logic por_busy, por_done, diag_done, retry_done;
  logic diag_en, retry_en;
  logic ot_hot, sp_fail, flag_hit;

  assign por_busy = (st_q == ST_POR);
  assign diag_en  = (st_q == ST_ARM) || (st_q == ST_RUN);
  assign retry_en = (st_q == ST_FLT);
  assign flag_hit = (|fault_flags) || ot_hot;

  hl_tick_timer #(.LIMIT(POR_TICKS)) u_por (
    .clk(clk), .rst_n(rst_n), .en(por_busy), .clr(!por_busy), .done(por_done)
  );

  hl_tick_timer #(.LIMIT(DIAG_TICKS)) u_diag (
    .clk(clk), .rst_n(rst_n), .en(diag_en), .clr(!diag_en), .done(diag_done)
  );

  hl_tick_timer #(.LIMIT(RETRY_TICKS)) u_retry (
    .clk(clk), .rst_n(rst_n), .en(retry_en), .clr(!retry_en), .done(retry_done)
  );

  hl_overtemp #(.TW(TW), .OT_TRIP(OT_TRIP), .OT_HYS(OT_HYS)) u_ot (
    .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .hot(ot_hot)
  );

  hl_sigpath #(.W(W), .TEST_AMP(TEST_AMP)) u_sp (
    .op(thr_op), .rel(thr_rel), .fail(sp_fail)
  );

  hl_schmitt #(.W(W)) u_latch (
    .field(smp_field), .op(thr_op), .rel(thr_rel), .cur(latch_q), .nxt(latch_nxt)
  );

  always_comb begin
    st_d    = st_q;
    latch_d = latch_q;
    pass_d  = 1'b0;
    unique case (st_q)
      ST_POR: if (por_done) st_d = ST_ARM;
      ST_ARM, ST_RUN: begin
        if (flag_hit || (diag_done && sp_fail)) begin
          st_d = ST_FLT;
        end else begin
          pass_d = diag_done;
          if (smp_valid) begin
            latch_d = latch_nxt;
            st_d    = ST_RUN;
          end
        end
      end
      ST_FLT: begin
        if (retry_done && !flag_hit && !sp_fail) begin
          st_d   = ST_ARM;
          pass_d = 1'b1;
        end
      end
      default: st_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_POR;
      latch_q   <= 1'b0;
      diag_pass <= 1'b0;
      smp_ready <= 1'b0;
    end else begin
      st_q      <= st_d;
      latch_q   <= latch_d;
      diag_pass <= pass_d;
      smp_ready <= 1'b1;
    end
  end

  assign out_code     = (st_q == ST_RUN) ? level_code(latch_q, invert) : CODE_FAULT;
  assign fault_active = (st_q == ST_FLT);
endmodule

// File: rtl/hall_latch_diag_chk.sv
module hall_latch_diag_chk #(
  parameter int NF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    out_code,
  input logic          fault_active,
  input logic          diag_pass,
  input logic          por_busy,
  input logic          latch_q,
  input logic [NF-1:0] fault_flags,
  input logic          smp_ready
);
  p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_code != 2'b10);

  p_por_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    por_busy |-> out_code == 2'b11);

  p_fault_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_active |-> out_code == 2'b11);

  p_flag_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fault_flags) && !por_busy) |=> fault_active);

  p_exit_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_active) |-> diag_pass);

  p_pass_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    diag_pass |-> !fault_active);

  p_hold_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && $past(fault_active)) |-> $stable(latch_q));

  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> smp_ready);
endmodule

bind hall_latch_diag hall_latch_diag_chk #(.NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_code(out_code), .fault_active(fault_active),
  .diag_pass(diag_pass), .por_busy(por_busy), .latch_q(latch_q),
  .fault_flags(fault_flags), .smp_ready(smp_ready)
);

// File: tb/hall_latch_diag_tb.sv
module hall_latch_diag_tb;
  localparam int W = 12, NF = 3, TW = 10;
  localparam int POR_T = 20, DIAG_T = 16, RETRY_T = 50, AMP = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic signed [W-1:0] smp_field = '0;
  logic signed [W-1:0] thr_op = 12'sd100;
  logic signed [W-1:0] thr_rel = -12'sd100;
  logic invert = 1'b0;
  logic [NF-1:0] fault_flags = '0;
  logic signed [TW-1:0] temp_c = 10'sd25;
  logic [1:0] out_code;
  logic diag_pass, fault_active;

  int checks = 0;
  int fails = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  hall_latch_diag #(.W(W), .NF(NF), .TW(TW), .POR_TICKS(POR_T), .DIAG_TICKS(DIAG_T),
                    .RETRY_TICKS(RETRY_T), .TEST_AMP(AMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_field(smp_field), .thr_op(thr_op), .thr_rel(thr_rel), .invert(invert),
    .fault_flags(fault_flags), .temp_c(temp_c), .out_code(out_code),
    .diag_pass(diag_pass), .fault_active(fault_active)
  );

  function automatic int exp_code(bit on, bit inv);
    return (on ^ inv) ? 0 : 1;
  endfunction

  function automatic bit model_next(int f, int op, int rel, bit cur);
    if (f > op) return 1'b1;
    if (f < rel) return 1'b0;
    return cur;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int f);
    smp_field = W'(f);
    smp_valid = 1'b1;
    model_on = model_next(f, int'(thr_op), int'(thr_rel), model_on);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_clear(input int limit, output int n);
    n = 0;
    while (fault_active === 1'b1 && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int pc;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1 reset code", out_code, 3);
    chk("R12 ready in reset", smp_ready, 0);
    chk("R6 reset fault_active", fault_active, 0);
    rst_n = 1'b1;

    repeat (10) @(negedge clk);
    chk("R1 power-on fault", out_code, 3);
    chk("R12 ready", smp_ready, 1);
    repeat (20) @(negedge clk);
    chk("R1 no sample yet", out_code, 3);

    send(50);
    chk("R3 in-band first sample off", out_code, exp_code(model_on, invert));
    chk("R3 off is HIGH", out_code, 1);

    send(100);  chk("R2 equal op holds", out_code, 1);
    send(101);  chk("R2 above op on", out_code, 0);
    send(-100); chk("R2 equal rel holds", out_code, 0);
    send(-101); chk("R2 below rel off", out_code, 1);

    invert = 1'b1; @(negedge clk);
    chk("R4 invert off", out_code, 0);
    send(300); chk("R4 invert on", out_code, 1);
    invert = 1'b0; @(negedge clk);
    chk("R4 standard on", out_code, 0);

    for (int i = 0; i < 400; i++) begin
      chk("R2 random", out_code, exp_code(model_on, invert));
      if ($urandom_range(7) == 0) invert = ~invert;
      if ($urandom_range(1) == 1) begin
        send(int'($urandom_range(600)) - 300);
      end else begin
        @(negedge clk);
      end
    end
    chk("R2 random tail", out_code, exp_code(model_on, invert));
    invert = 1'b0;

    pc = 0;
    for (int i = 0; i < 10 * DIAG_T; i++) begin
      @(negedge clk);
      if (diag_pass) pc++;
    end
    chk("R11 pass rate", pc, 10);

    send(200);
    chk("R2 set on", out_code, 0);
    fault_flags = 3'b010;
    smp_field = -12'sd300;
    smp_valid = 1'b1;
    @(negedge clk);
    fault_flags = '0;
    chk("R5 fault entry", fault_active, 1);
    chk("R5 fault code", out_code, 3);
    wait_clear(500, n);
    smp_valid = 1'b0;
    chk("R6 retry length", n, RETRY_T);
    chk("R7 exit pass", diag_pass, 1);
    chk("R7 fault until sample", out_code, 3);
    send(0);
    chk("R10 R7 held on resumed", out_code, 0);

    fault_flags = 3'b001;
    invert = 1'b1;
    repeat (3 * RETRY_T) @(negedge clk);
    chk("R6 persistent fault", fault_active, 1);
    chk("R4 fault ignores invert", out_code, 3);
    invert = 1'b0;
    fault_flags = '0;
    wait_clear(RETRY_T + 2, n);
    chk("R6 recovers after clear", fault_active, 0);
    send(-200);
    chk("R7 resume off", out_code, 1);

    temp_c = 10'sd204;
    repeat (30) @(negedge clk);
    chk("R8 below trip", fault_active, 0);
    temp_c = 10'sd205;
    repeat (3) @(negedge clk);
    chk("R8 trip", fault_active, 1);
    temp_c = 10'sd190;
    repeat (2 * RETRY_T + 5) @(negedge clk);
    chk("R8 hysteresis hold", fault_active, 1);
    temp_c = 10'sd180;
    repeat (RETRY_T + 3) @(negedge clk);
    chk("R8 cleared", fault_active, 0);
    send(0);
    chk("R8 resume held off", out_code, 1);

    thr_op = 12'sd500;
    repeat (DIAG_T + 2) @(negedge clk);
    chk("R9 operate leg missing", fault_active, 1);
    thr_op = 12'sd100;
    repeat (RETRY_T + 3) @(negedge clk);
    chk("R9 recovered", fault_active, 0);
    thr_rel = -12'sd450;
    repeat (DIAG_T + 2) @(negedge clk);
    chk("R9 release leg missing", fault_active, 1);
    thr_rel = -12'sd100;
    repeat (RETRY_T + 3) @(negedge clk);
    chk("R9 recovered again", fault_active, 0);
    send(150);
    chk("R9 normal output", out_code, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule